// File: doc/BRIEF.md
# Daisy-Chainable Serial Control Port

This block is the slave side of a synchronous serial link that a host uses to program a 16-bit control word and to read a 16-bit status word in the same frame. The host lowers chip select, toggles the serial clock and drives serial data in. The port returns status bits on a shared serial data line that it drives only while it is selected. Incoming bits go through a shift register and reach the parallel control register only when chip select rises at the end of a complete frame.

All three pin inputs are brought into the system clock domain through synchronizers, and edges are detected there. The system clock must be many times faster than the serial clock: at least eight system cycles per serial half period. A small state machine sequences each frame. It has four states. `ST_IDLE` waits with the output line released. `ST_SHIFT` is the active frame. `ST_COMMIT` writes the received word. `ST_DROP` throws away a malformed frame.

The transitions are these. A chip select fall in `ST_IDLE` loads the status word and moves to `ST_SHIFT`. A chip select rise in `ST_SHIFT` moves to `ST_COMMIT` when the bit count is a nonzero multiple of 16, and to `ST_DROP` otherwise. `ST_COMMIT` and `ST_DROP` both return to `ST_IDLE` on the next cycle. Because bits pass straight through the shift register, two ports can be chained: a 32-bit frame programs both of them.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset, `ctrl_word` is 16'h2000 (bit 13, the overcurrent-shutdown enable, set; all else clear) and `sdo_en` is low.
- R2: `sdo_en` is low whenever chip select has been high for two or more synchronized cycles, and it is high throughout a frame once chip select has been low for a few cycles.
- R3: Serial data in is sampled on each falling edge of the serial clock, and the first sampled bit becomes bit 0 of the received word.
- R4: `sdo` changes only after rising edges of the serial clock. After rising edge k (k = 1..16) of a frame it carries status bit k-1, so bit 0 goes out first.
- R5: The status word is captured at the chip select fall. Changes to `status_word` during the frame do not alter the bits sent.
- R6: `ctrl_word` does not change during a frame. It is updated only after chip select rises.
- R7: Only bit 0 (status reset), bits 1 to 6 (channel 1 low, channel 1 high, channel 2 low, channel 2 high, channel 3 low, channel 3 high) and bit 13 (overcurrent-shutdown enable) are stored. All other bits of `ctrl_word` read 0.
- R8: In a frame of 32 clocks, `sdo` carries the first 16 received bits after rising edges 17 to 32, and the last 16 received bits are committed.
- R9: A frame whose falling-edge count is zero or not a multiple of 16 is discarded, and `ctrl_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip select from host, active low |
| sck_pin | input | 1 | Serial clock from host |
| sdi_pin | input | 1 | Serial data from host |
| status_word | input | 16 | Parallel status to be returned |
| sdo | output | 1 | Serial data toward host |
| sdo_en | output | 1 | Output enable for the shared data pad |
| ctrl_word | output | 16 | Committed control register |

## Verification
A table of frames covers several cases. Full 16-bit words with sparse, dense and all-zero bit patterns separate wrong bit order and wrong masking from correct storage. A 32-clock chained frame with distinct halves shows whether the pass-through and the last-word commit are wired correctly. Short and empty frames must leave the previous control value in place, which exposes a commit that ignores the bit count. Each frame also flips `status_word` mid-frame, so a status capture taken later than the chip select fall shows up as wrong output bits.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DROP   = 2'd3
    } port_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= RST_VAL;
                end else if (i == 0) begin
                    chain_q[i] <= d;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import serial_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_fall,
    input  logic        cs_rise,
    input  logic        aligned,
    output port_state_e state,
    output logic        load,
    output logic        active,
    output logic        commit,
    output logic        drive
);
    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_d = aligned ? ST_COMMIT : ST_DROP;
            ST_COMMIT: state_d = ST_IDLE;
            ST_DROP:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load   = (state_q == ST_IDLE) && cs_fall;
        active = (state_q == ST_SHIFT) && !cs_rise;
        commit = (state_q == ST_COMMIT);
        drive  = (state_q == ST_SHIFT);
    end

    assign state = state_q;

    // R2
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cs_fall) |=> (state_q == ST_SHIFT));

    // R9
    misaligned_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise && !aligned) |=> (state_q == ST_DROP));
endmodule

// File: rtl/shift_path.sv
module shift_path #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic              sck_fall,
    input  logic              sck_rise,
    input  logic              sdi,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              aligned,
    output logic              sdo
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              seen_q;
    logic              sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
            sdo_q   <= 1'b0;
        end else if (load) begin
            shreg_q <= status_word;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
            sdo_q   <= status_word[0];
        end else if (active) begin
            if (sck_fall) begin
                shreg_q <= {sdi, shreg_q[WORD_W-1:1]};
                cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                seen_q  <= 1'b1;
            end
            if (sck_rise) begin
                sdo_q <= shreg_q[0];
            end
        end
    end

    assign rx_word = shreg_q;
    assign aligned = seen_q && (cnt_q == '0);
    assign sdo     = sdo_q;

    // R4
    sdo_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !sck_rise) |=> $stable(sdo_q));

    // R3
    shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(active && sck_fall)) |=> $stable(shreg_q));
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
    import serial_port_pkg::*;
#(
    parameter int          WORD_W      = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] KEEP_MASK   = 16'h207F,
    parameter logic [15:0] RESET_WORD  = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sck_pin,
    input  logic              sdi_pin,
    input  logic [WORD_W-1:0] status_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic [WORD_W-1:0] ctrl_word
);
    localparam logic [WORD_W-1:0] KEEP  = WORD_W'(KEEP_MASK);
    localparam logic [WORD_W-1:0] RST_V = WORD_W'(RESET_WORD) & KEEP;

    logic cs_s, sck_s, sdi_s;
    logic cs_d, sck_d;
    logic cs_fall, cs_rise, sck_fall, sck_rise;
    logic load, active, commit, drive, aligned;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] ctrl_q;
    port_state_e state;

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync
        (.clk(clk), .rst_n(rst_n), .d(cs_n_pin), .q(cs_s));
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync
        (.clk(clk), .rst_n(rst_n), .d(sck_pin), .q(sck_s));
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync
        (.clk(clk), .rst_n(rst_n), .d(sdi_pin), .q(sdi_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign cs_fall  = cs_d & ~cs_s;
    assign cs_rise  = ~cs_d & cs_s;
    assign sck_fall = sck_d & ~sck_s;
    assign sck_rise = ~sck_d & sck_s;

    frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .aligned(aligned), .state(state), .load(load), .active(active),
        .commit(commit), .drive(drive)
    );

    shift_path #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .active(active),
        .sck_fall(sck_fall), .sck_rise(sck_rise), .sdi(sdi_s),
        .status_word(status_word), .rx_word(rx_word), .aligned(aligned),
        .sdo(sdo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= RST_V;
        else if (commit) ctrl_q <= rx_word & KEEP;
    end

    assign ctrl_word = ctrl_q;
    assign sdo_en    = drive;

    // R2
    released_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !sdo_en);

    // R2
    enable_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> $past(cs_fall));

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable(ctrl_q));

    // R7
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~KEEP) == '0);
endmodule

// File: tb/serial_ctrl_port_test.sv
module serial_ctrl_port_test;
    localparam int HP = 8;
    localparam int NV = 6;
    localparam logic [15:0] KEEP = 16'h207F;

    localparam int          V_BITS [NV] = '{16, 16, 10, 16, 32, 0};
    localparam logic [31:0] V_DATA [NV] = '{32'h0000_007E, 32'h0000_FFFF,
                                            32'h0000_0155, 32'h0000_0000,
                                            32'h2015_FFFF, 32'h0000_0000};
    localparam logic [15:0] V_STAT [NV] = '{16'hA5C3, 16'h0001, 16'h8000,
                                            16'h7FFE, 16'h3C3C, 16'h1234};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1;
    logic sck_pin = 1'b0;
    logic sdi_pin = 1'b0;
    logic [15:0] status_word = '0;
    logic sdo, sdo_en;
    logic [15:0] ctrl_word;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] exp_ctrl;

    always #4 clk = ~clk;

    serial_ctrl_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .sdi_pin(sdi_pin), .status_word(status_word), .sdo(sdo),
        .sdo_en(sdo_en), .ctrl_word(ctrl_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input int nbits, input logic [31:0] data,
                             input logic [15:0] stat);
        logic [15:0] held;
        logic        want;
        held = stat;
        status_word = stat;
        wait_cyc(2);
        cs_n_pin = 1'b0;
        wait_cyc(HP);
        check(sdo_en === 1'b1, "R2 enable in frame", 32'(sdo_en), 1);
        for (int k = 0; k < nbits; k++) begin
            sdi_pin = data[k];
            if (k == 3) status_word = ~stat;   // R5 late change ignored
            sck_pin = 1'b1;
            wait_cyc(HP);
            want = (k < 16) ? held[k] : data[k-16];
            if (k < 16)
                check(sdo === want, "R4/R5 status bit", 32'(sdo), 32'(want));
            else
                check(sdo === want, "R8 pass-through bit", 32'(sdo), 32'(want));
            if (k == 8)
                check(ctrl_word === exp_ctrl, "R6 hold mid-frame", 32'(ctrl_word),
                      32'(exp_ctrl));
            sck_pin = 1'b0;
            wait_cyc(HP);
        end
        cs_n_pin = 1'b1;
        if (nbits > 0 && nbits % 16 == 0)
            exp_ctrl = data[nbits-16 +: 16] & KEEP;   // R3 R7 R8
        wait_cyc(12);
        check(sdo_en === 1'b0, "R2 released after frame", 32'(sdo_en), 0);
        if (nbits > 0 && nbits % 16 == 0)
            check(ctrl_word === exp_ctrl, "R3/R7/R8 commit", 32'(ctrl_word),
                  32'(exp_ctrl));
        else
            check(ctrl_word === exp_ctrl, "R9 discard", 32'(ctrl_word),
                  32'(exp_ctrl));
    endtask

    initial begin
        wait_cyc(5);
        check(ctrl_word === 16'h2000, "R1 reset ctrl", 32'(ctrl_word), 32'h2000);
        check(sdo_en === 1'b0, "R1 reset enable", 32'(sdo_en), 0);
        rst_n = 1'b1;
        exp_ctrl = 16'h2000;
        wait_cyc(5);

        for (int v = 0; v < NV; v++)
            run_frame(V_BITS[v], V_DATA[v], V_STAT[v]);

        // R9: 17 clocks is not a multiple of 16
        run_frame(17, 32'h0001_0000, 16'h0F0F);
        // R7: only kept bits survive
        run_frame(16, 32'h0000_DF80, 16'hFFFF);
        check(ctrl_word === 16'h0000, "R7 unused bits zero", 32'(ctrl_word), 0);

        rst_n = 1'b0;
        wait_cyc(3);
        check(ctrl_word === 16'h2000, "R1 re-reset ctrl", 32'(ctrl_word), 32'h2000);
        rst_n = 1'b1;
        wait_cyc(3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule